// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Display Driver

This block shows an unsigned binary value between 0 and 99 as two decimal digits on a seven-segment display. It splits the value into a tens digit and a ones digit and turns each digit into a segment pattern. It then shares one segment bus between the two digits by switching between them over time. A one-hot enable vector selects which digit position lights at any moment. The enable vector is sized for a multi-digit display, and only two positions of it are ever driven.

The switch rate comes from a clock-enable divider. Parameters set the clock frequency and the rate at which each digit is refreshed. A tens digit of zero is left dark, so single-digit values show one digit only. A value of zero still shows a 0 in the ones position. Values outside the decimal range leave both digits dark. A synchronous clear restarts the scan at the tens position and turns every enable off.

Top module: `mux2seg_disp`

## Requirements
- R1: The segment bus is 7 bits in abcdefg order, bit 6 = a down to bit 0 = g, active high. The ones digit patterns are 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=0011111, 7=1110000, 8=1111111, 9=1110011.
- R2: For values 1 to 9, the tens position shows 0000000 (blank).
- R3: For values 10 to 99, the tens position shows the pattern of the value's tens digit and the ones position shows the pattern of its ones digit, using the R1 table.
- R4: A value of 0 shows a blank tens digit and 1111110 in the ones position.
- R5: A value of 100 or more shows 0000000 in both positions.
- R6: Outside clear, exactly one enable bit is active. Enable bit 1 (00000010) marks the tens digit and bit 0 (00000001) marks the ones digit. All other enable bits stay 0 at all times.
- R7: Each digit stays enabled for exactly CLK_HZ/SCAN_HZ clock cycles, and then the other digit is enabled.
- R8: A clock edge with clear high drives the enables and the segments to all zero and resets the scan. The first edge after clear is released enables the tens digit.
- R9: The segment and enable outputs are registered. A new value shows on the outputs after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clear | input | 1 | Synchronous clear, active high |
| value_i | input | VAL_W (8) | Unsigned binary value to show |
| seg_o | output | 7 | Segment bus, abcdefg, active high |
| en_o | output | EN_W (8) | One-hot digit enables |

## Verification
The bench builds the block with CLK_HZ=2000 and SCAN_HZ=250, which gives an 8-cycle dwell per digit. This makes the R7 timing sequence short enough to check cycle by cycle after each clear. It keeps the default comparison-ladder digit split and the default enable positions, 1 for tens and 0 for ones. Random values over the full 8-bit range exercise the blanking above 99. Directed values cover the decade edges 9/10, 19/20, 99/100 and 0.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;

   localparam int SEG_W = 7;
   typedef logic [SEG_W-1:0] seg_t;

   // decimal digit to abcdefg pattern (bit 6 = a); codes above 9 give dark
   function automatic seg_t digit_to_seg(input logic [3:0] d);
      seg_t s;
      case (d)
         4'd0: s = 7'b1111110;
         4'd1: s = 7'b0110000;
         4'd2: s = 7'b1101101;
         4'd3: s = 7'b1111001;
         4'd4: s = 7'b0110011;
         4'd5: s = 7'b1011011;
         4'd6: s = 7'b0011111;
         4'd7: s = 7'b1110000;
         4'd8: s = 7'b1111111;
         4'd9: s = 7'b1110011;
         default: s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/scan_tick.sv
module scan_tick #(
   parameter int DIV = 100000
) (
   input  logic clk,
   input  logic clear,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (clear)            cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST) && !clear;
endmodule

// File: rtl/dec_split.sv
module dec_split #(
   parameter int VAL_W      = 8,
   parameter int SPLIT_MODE = 0   // 0: compare ladder, 1: reciprocal multiply
) (
   input  logic [VAL_W-1:0] value,
   output logic [3:0]       tens,
   output logic [3:0]       ones,
   output logic             over
);
   logic [3:0] tens_w;

   assign over = (32'(value) > 32'd99);

   generate
      if (SPLIT_MODE == 0) begin : g_ladder
         always_comb begin
            tens_w = 4'd0;
            for (int k = 1; k < 10; k++) begin
               if (32'(value) >= 32'(10 * k)) tens_w = 4'(k);
            end
         end
      end else begin : g_recip
         // floor(v/10) == (v*205)>>11 holds for every v below 180
         always_comb tens_w = 4'((32'(value) * 32'd205) >> 11);
      end
   endgenerate

   always_comb begin
      tens = tens_w;
      ones = 4'(32'(value) - 32'(tens_w) * 32'd10);
   end
endmodule

// File: rtl/seg_digit.sv
module seg_digit
   import segdisp_pkg::*;
(
   input  logic [3:0] digit,
   input  logic       blank,
   output seg_t       seg
);
   assign seg = blank ? '0 : digit_to_seg(digit);
endmodule

// File: rtl/mux2seg_disp.sv
module mux2seg_disp
   import segdisp_pkg::*;
#(
   parameter int CLK_HZ     = 100_000_000,
   parameter int SCAN_HZ    = 1000,
   parameter int VAL_W      = 8,
   parameter int EN_W       = 8,
   parameter int TENS_POS   = 1,
   parameter int ONES_POS   = 0,
   parameter int SPLIT_MODE = 0
) (
   input  logic             clk,
   input  logic             clear,
   input  logic [VAL_W-1:0] value_i,
   output logic [6:0]       seg_o,
   output logic [EN_W-1:0]  en_o
);
   localparam int DIV = CLK_HZ / SCAN_HZ;
   localparam logic [EN_W-1:0] EN_TENS = EN_W'(1) << TENS_POS;
   localparam logic [EN_W-1:0] EN_ONES = EN_W'(1) << ONES_POS;

   generate
      if (DIV < 2)                 begin : g_bad_div  $error("CLK_HZ/SCAN_HZ must be 2 or more"); end
      if (VAL_W < 7)               begin : g_bad_w    $error("VAL_W must hold 99"); end
      if (TENS_POS == ONES_POS)    begin : g_bad_pos  $error("digit positions must differ"); end
      if (TENS_POS >= EN_W || ONES_POS >= EN_W)
                                   begin : g_bad_en   $error("digit position beyond EN_W"); end
      if (SPLIT_MODE != 0 && SPLIT_MODE != 1)
                                   begin : g_bad_mode $error("SPLIT_MODE must be 0 or 1"); end
   endgenerate

   logic       tick;
   logic [3:0] tens, ones;
   logic       over;
   seg_t       tens_seg, ones_seg;
   logic       sel_ones;

   scan_tick #(.DIV(DIV)) u_tick (
      .clk   (clk),
      .clear (clear),
      .tick  (tick)
   );

   dec_split #(.VAL_W(VAL_W), .SPLIT_MODE(SPLIT_MODE)) u_split (
      .value (value_i),
      .tens  (tens),
      .ones  (ones),
      .over  (over)
   );

   seg_digit u_tens (
      .digit (tens),
      .blank (over || (tens == 4'd0)),
      .seg   (tens_seg)
   );

   seg_digit u_ones (
      .digit (ones),
      .blank (over),
      .seg   (ones_seg)
   );

   always_ff @(posedge clk) begin
      if (clear) begin
         sel_ones <= 1'b0;
         seg_o    <= '0;
         en_o     <= '0;
      end else begin
         if (tick) sel_ones <= ~sel_ones;
         seg_o <= sel_ones ? ones_seg : tens_seg;
         en_o  <= sel_ones ? EN_ONES : EN_TENS;
      end
   end
endmodule

// File: rtl/disp_chk.sv
module disp_chk #(
   parameter int VAL_W    = 8,
   parameter int EN_W     = 8,
   parameter int TENS_POS = 1,
   parameter int ONES_POS = 0
) (
   input logic             clk,
   input logic             clear,
   input logic [VAL_W-1:0] value_i,
   input logic [6:0]       seg_o,
   input logic [EN_W-1:0]  en_o
);
   localparam logic [EN_W-1:0] USED = (EN_W'(1) << TENS_POS) | (EN_W'(1) << ONES_POS);

   logic armed = 1'b0;
   always_ff @(posedge clk) if (clear) armed <= 1'b1;

   a_r8_clear_dark: assert property (@(posedge clk) disable iff (!armed)
      clear |=> (en_o == '0 && seg_o == '0));

   a_r8_tens_first: assert property (@(posedge clk) disable iff (!armed)
      ($past(clear) && !clear) |=> en_o[TENS_POS]);

   a_r6_one_enable: assert property (@(posedge clk) disable iff (!armed)
      !clear |=> ($countones(en_o) == 1));

   a_r6_unused_off: assert property (@(posedge clk) disable iff (!armed)
      (en_o & ~USED) == '0);

   a_r5_over_dark: assert property (@(posedge clk) disable iff (!armed)
      (32'(value_i) > 32'd99 && !clear) |=> (seg_o == '0));

   a_r2_tens_blank: assert property (@(posedge clk) disable iff (!armed)
      (32'(value_i) < 32'd10 && !clear) |=> (!en_o[TENS_POS] || seg_o == '0));
endmodule

bind mux2seg_disp disp_chk #(
   .VAL_W(VAL_W), .EN_W(EN_W), .TENS_POS(TENS_POS), .ONES_POS(ONES_POS)
) u_chk (
   .clk(clk), .clear(clear), .value_i(value_i), .seg_o(seg_o), .en_o(en_o)
);

// File: tb/sim_mux2seg_disp.sv
`timescale 1ns/1ps
module sim_mux2seg_disp;
   localparam int CLK_HZ  = 2000;
   localparam int SCAN_HZ = 250;
   localparam int DIV     = CLK_HZ / SCAN_HZ;
   localparam logic [7:0] EN_T = 8'b0000_0010;
   localparam logic [7:0] EN_O = 8'b0000_0001;

   logic       clk = 1'b0;
   logic       clear = 1'b1;
   logic [7:0] value_i = 8'd0;
   logic [6:0] seg_o;
   logic [7:0] en_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mux2seg_disp #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ)) u0 (
      .clk(clk), .clear(clear), .value_i(value_i), .seg_o(seg_o), .en_o(en_o)
   );

   function automatic logic [6:0] pat(input int d);
      case (d)
         0: return 7'b1111110;  1: return 7'b0110000;
         2: return 7'b1101101;  3: return 7'b1111001;
         4: return 7'b0110011;  5: return 7'b1011011;
         6: return 7'b0011111;  7: return 7'b1110000;
         8: return 7'b1111111;  9: return 7'b1110011;
         default: return 7'b0000000;
      endcase
   endfunction

   function automatic logic [6:0] exp_tens(input int v);
      if (v > 99 || v < 10) return 7'b0;
      return pat(v / 10);
   endfunction

   function automatic logic [6:0] exp_ones(input int v);
      if (v > 99) return 7'b0;
      return pat(v % 10);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // set a value, then watch two full scan periods
   task automatic show_value(input int v, input string req);
      int bad_seg = 0, bad_en = 0, n_t = 0, n_o = 0;
      logic [6:0] last_act = '0, last_exp = '0;
      value_i = 8'(v);
      @(negedge clk);                       // R9: one edge of latency
      for (int i = 0; i < 2 * DIV + 2; i++) begin
         if (en_o == EN_T) begin
            n_t++;
            if (seg_o != exp_tens(v)) begin bad_seg++; last_act = seg_o; last_exp = exp_tens(v); end
         end else if (en_o == EN_O) begin
            n_o++;
            if (seg_o != exp_ones(v)) begin bad_seg++; last_act = seg_o; last_exp = exp_ones(v); end
         end else bad_en++;
         @(negedge clk);
      end
      check(bad_seg == 0, req, $sformatf("segments v=%0d", v), {25'd0, last_act}, {25'd0, last_exp});
      check(bad_en == 0 && n_t > 0 && n_o > 0, "R6", $sformatf("enables v=%0d", v),
            32'(bad_en), 32'd0);
   endtask

   task automatic clear_and_scan(input int v);
      int bad = 0;
      logic [7:0] a = '0, e = '0;
      value_i = 8'(v);
      clear = 1'b1;
      @(negedge clk);
      check(en_o == 8'b0 && seg_o == 7'b0, "R8", "outputs dark in clear", {17'd0, en_o, seg_o}, 32'd0);
      @(negedge clk);
      check(en_o == 8'b0, "R8", "enables stay off while clear held", 32'(en_o), 32'd0);
      clear = 1'b0;
      @(negedge clk);
      check(en_o == EN_T, "R8", "tens first after clear", 32'(en_o), 32'(EN_T));
      for (int n = 0; n < 4 * DIV; n++) begin
         logic [7:0] ee;
         ee = ((n / DIV) % 2 == 0) ? EN_T : EN_O;
         if (en_o != ee) begin bad++; a = en_o; e = ee; end
         @(negedge clk);
      end
      check(bad == 0, "R7", "dwell of DIV cycles per digit", 32'(a), 32'(e));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(en_o == 8'b0 && seg_o == 7'b0, "R8", "reset state", {17'd0, en_o, seg_o}, 32'd0);
      clear_and_scan(42);
      show_value(0,   "R4");
      show_value(1,   "R2");
      show_value(3,   "R2");
      show_value(9,   "R2");
      for (int d = 0; d < 10; d++) show_value(50 + d, "R1");
      show_value(10,  "R3");
      show_value(19,  "R3");
      show_value(20,  "R3");
      show_value(99,  "R3");
      show_value(100, "R5");
      show_value(255, "R5");
      void'($urandom(32'd1234));
      for (int i = 0; i < 40; i++) begin
         int v;
         v = int'($urandom_range(0, 255));
         show_value(v, (v > 99) ? "R5" : (v == 0) ? "R4" : (v < 10) ? "R2" : "R3");
      end
      clear_and_scan(7);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule